// File: doc/BRIEF.md
# Fractional Rate Adjusting Clock Divider

This block divides a master clock down to a single timing tick that heads an audio clock tree. Bit clock, word select and oversampling dividers further down the tree hang off that tick. The nominal tick period, in master cycles, is a programmable divide count. Two mechanisms let the tick track a remote sample rate without a second clock domain:

- **Phase accumulator.** A 2^ACC_W-modulo accumulator loses the magnitude of a signed rate word on every enabled master cycle. Each borrow out of it marks one correction.
- **Period adjustment.** A pending correction is spent on the next divider period to begin. That period is stretched or shrunk by exactly one master cycle.

The result is a correction density, in parts per 2^ACC_W master cycles, equal to the rate magnitude. The sign of the rate word chooses the direction. Software or a tracking loop drives the divide count and rate word. The enable starts and stops the divider, and each start begins from a known phase.

Top module: `frac_rate_div`

## Requirements
- R1: While rst_ni is low, and on every cycle that follows a cycle with en_i low, tick_o is 0. A new enable starts from the same state as after reset: accumulator all ones, no pending correction, counter at the start of a period.
- R2: After at least one cycle with en_i low, the first tick_o pulse follows the D-th rising edge at which en_i is sampled high. D is the divide count, and a divide count of 0 counts as 1.
- R3: When rate_i[RATE_W-2:0] is zero, every tick interval equals the nominal divide count, whatever the value of rate_i[RATE_W-1].
- R4: The accumulator starts at all ones. On each enabled edge it subtracts rate_i[RATE_W-2:0] modulo 2^ACC_W, and a borrow is an underflow. After k enabled edges at magnitude m, exactly floor(k*m/2^ACC_W) underflows have occurred.
- R5: An underflow marks a correction pending. The period that starts at the next tick boundary uses the pending correction and clears it. With rate_i[RATE_W-1]=0, that period is divide count + 1.
- R6: With rate_i[RATE_W-1]=1, a corrected period is divide count - 1, but never less than 1 cycle.
- R7: Further underflows while a correction is already pending are not accumulated. A period never differs from the nominal count by more than one cycle.
- R8: A divide count of 0 behaves as a divide count of 1, and a divide count of 1 with shortening keeps a one-cycle period.
- R9: tick_o is high for exactly one master cycle at the end of each period whose length is 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the divider at its start state |
| div_cnt_i | input | DIV_W (16) | Nominal period in master cycles |
| rate_i | input | RATE_W (9) | Bit RATE_W-1: 0 lengthen, 1 shorten; lower bits: correction magnitude |
| tick_o | output | 1 | One-cycle timing tick at the end of each period |

## Verification
The bench builds the divider with ACC_W=12 and DIV_W=8. With ACC_W=12, a magnitude of 255 underflows roughly every sixteen cycles instead of every four thousand. Exact tick sequences can then be worked out by hand over the first few periods, showing where a correction lands and where it is deferred. That setting also puts two or more underflows inside one 40-cycle period, which exposes any queuing of corrections. With a magnitude of 100, a two-thousand-cycle run holds about fifty corrections, enough to compare the applied count against floor(k*m/4096) within one.

// File: rtl/frd_pkg.sv
package frd_pkg;

  typedef enum logic {
    ADJ_LONG  = 1'b0,
    ADJ_SHORT = 1'b1
  } adj_dir_e;

endpackage

// File: rtl/frd_phase_acc.sv
module frd_phase_acc #(
  parameter int ACC_W = 20,
  parameter int MAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             uf_o
);

  localparam int SUB_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUB_W-1:0] diff;

  assign diff = {1'b0, acc_q} - SUB_W'(mag_i);
  assign uf_o = en_i & diff[ACC_W];

  // disabled: reload full scale so every run starts at the same phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '1;
    else if (!en_i) acc_q <= '1;
    else            acc_q <= diff[ACC_W-1:0];
  end

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '1);

  assert_wrap_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && uf_o) |=> acc_q > $past(acc_q));

  assert_descend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !uf_o && mag_i != '0) |=> acc_q < $past(acc_q));

  assert_zero_mag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_i == '0) |-> !uf_o);

endmodule

// File: rtl/frd_adj_pend.sv
module frd_adj_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic uf_i,
  input  logic take_i,
  output logic pend_o
);

  logic pend_q;

  // set wins over take: an underflow on the boundary edge counts for the next period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (!en_i)  pend_q <= 1'b0;
    else if (uf_i)   pend_q <= 1'b1;
    else if (take_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_o && !take_i) |=> pend_o);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && take_i && !uf_i) |=> !pend_o);

  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && uf_i) |=> pend_o);

endmodule

// File: rtl/frd_period_cnt.sv
module frd_period_cnt
  import frd_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pend_i,
  input  adj_dir_e         dir_i,
  output logic             take_o,
  output logic             tick_o
);

  localparam int LEN_W = DIV_W + 1;
  typedef logic [LEN_W-1:0] len_t;

  logic [DIV_W-1:0] rem_q, rem_d;
  logic             tick_q;
  len_t             nom, adj_len, nxt;

  always_comb begin
    nom     = (div_i == '0) ? len_t'(1) : {1'b0, div_i};
    adj_len = nom;
    if (pend_i) begin
      if (dir_i == ADJ_LONG)    adj_len = nom + len_t'(1);
      else if (nom > len_t'(1)) adj_len = nom - len_t'(1);
    end
  end

  assign take_o = en_i && (rem_q == '0);

  always_comb begin
    if (!en_i)       nxt = nom - len_t'(1);
    else if (take_o) nxt = adj_len - len_t'(1);
    else             nxt = {1'b0, rem_q} - len_t'(1);
    rem_d = nxt[DIV_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      tick_q <= take_o;
    end
  end

  assign tick_o = tick_q;

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);

  assert_start_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> len_t'(rem_q) == $past(nom) - len_t'(1));

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && rem_q != '0) |=> !tick_o);

  assert_step_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (len_t'(rem_q) <= $past(nom)) &&
               (len_t'(rem_q) + len_t'(2) >= $past(nom)));

  assert_floor_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && nom == len_t'(1)) |=> rem_q <= DIV_W'(1));

endmodule

// File: rtl/frac_rate_div.sv
module frac_rate_div
  import frd_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int RATE_W = 9,
  parameter int ACC_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  div_cnt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  localparam int MAG_W = RATE_W - 1;

  logic     uf, pend, take;
  adj_dir_e dir;

  assign dir = adj_dir_e'(rate_i[RATE_W-1]);

  frd_phase_acc #(
    .ACC_W (ACC_W),
    .MAG_W (MAG_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mag_i  (rate_i[MAG_W-1:0]),
    .uf_o   (uf)
  );

  frd_adj_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .uf_i   (uf),
    .take_i (take),
    .pend_o (pend)
  );

  frd_period_cnt #(
    .DIV_W (DIV_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_cnt_i),
    .pend_i (pend),
    .dir_i  (dir),
    .take_o (take),
    .tick_o (tick_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !tick_o);

endmodule

// File: tb/test_frac_rate_div.sv
`timescale 1ns/1ps
module test_frac_rate_div;

  localparam int DIV_W  = 8;
  localparam int RATE_W = 9;
  localparam int ACC_W  = 12;
  localparam int LOG_N  = 256;
  localparam int NVEC   = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [DIV_W-1:0]  div = '0;
  logic [RATE_W-1:0] rate = '0;
  logic              tick;

  int n_run = 0;
  int n_fail = 0;
  int ec = 0;
  int log_n = 0;
  int dbl = 0;
  logic prev_tick = 1'b0;
  int tick_log [LOG_N];

  always #2.5 clk = ~clk;

  frac_rate_div #(
    .DIV_W  (DIV_W),
    .RATE_W (RATE_W),
    .ACC_W  (ACC_W)
  ) i_frac_rate_div (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .div_cnt_i (div),
    .rate_i    (rate),
    .tick_o    (tick)
  );

  // enabled-edge counter and tick log, sampled away from the active edge
  always @(posedge clk) ec <= en ? ec + 1 : 0;

  always @(negedge clk) begin
    if (tick) begin
      if (log_n < LOG_N) tick_log[log_n] = ec;
      log_n = log_n + 1;
      if (prev_tick) dbl = dbl + 1;
    end
    prev_tick = tick;
  end

  typedef struct packed {
    logic [7:0]      dv;
    logic [8:0]      rt;
    logic [4:0][7:0] ex;
  } vec_t;

  // ex[0] is the first-tick latency, ex[1..4] the following intervals
  localparam vec_t VECS [NVEC] = '{
    '{8'd10, 9'h0FF, {8'd11, 8'd10, 8'd11, 8'd10, 8'd10}},
    '{8'd10, 9'h1FF, {8'd9,  8'd10, 8'd9,  8'd10, 8'd10}},
    '{8'd40, 9'h0FF, {8'd41, 8'd41, 8'd41, 8'd41, 8'd40}},
    '{8'd7,  9'h000, {8'd7,  8'd7,  8'd7,  8'd7,  8'd7 }},
    '{8'd7,  9'h100, {8'd7,  8'd7,  8'd7,  8'd7,  8'd7 }},
    '{8'd1,  9'h000, {8'd1,  8'd1,  8'd1,  8'd1,  8'd1 }},
    '{8'd0,  9'h000, {8'd1,  8'd1,  8'd1,  8'd1,  8'd1 }}
  };

  function automatic string vec_req(input int v);
    case (v)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      6: return "R8";
      default: return "R3";
    endcase
  endfunction

  function automatic int ival(input int i);
    return (i == 0) ? tick_log[0] : tick_log[i] - tick_log[i-1];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] d, input logic [8:0] r, input int n);
    @(negedge clk);
    en = 1'b0;
    div = d;
    rate = r;
    repeat (3) @(negedge clk);
    log_n = 0;
    dbl = 0;
    en = 1'b1;
    for (int t = 0; t < 5000 && log_n < n; t++) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic long_run(input logic [8:0] r, input int adj_len, input string req);
    int adj, bad, ufs;
    run_vec(8'd10, r, 200);
    adj = 0;
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      if (ival(i) == adj_len) adj++;
      else if (ival(i) != 10) bad++;
    end
    ufs = (tick_log[199] * 100) / 4096;
    chk(req, "intervals off nominal by more than one", bad, 0);
    chk("R4", "applied corrections below floor(k*m/2^12)-1", int'(adj >= ufs - 1), 1);
    chk("R4", "applied corrections above floor(k*m/2^12)", int'(adj <= ufs), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "tick during reset", int'(tick), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "tick after reset", int'(tick), 0);

    // R1: disabled divider stays silent
    div = 8'd3;
    log_n = 0;
    repeat (50) @(negedge clk);
    chk("R1", "ticks while disabled", log_n, 0);

    // table walk: R2 latency plus per-vector intervals
    for (int v = 0; v < NVEC; v++) begin
      run_vec(VECS[v].dv, VECS[v].rt, 5);
      chk("R2", $sformatf("vec %0d first tick latency", v), tick_log[0], int'(VECS[v].ex[0]));
      for (int i = 1; i < 5; i++)
        chk(vec_req(v), $sformatf("vec %0d interval %0d", v, i), ival(i), int'(VECS[v].ex[i]));
    end

    // R9: one-cycle pulse check on a nominal-10 run
    run_vec(8'd10, 9'h0FF, 5);
    chk("R9", "consecutive tick cycles", dbl, 0);

    // R8: divide count 1 with shortening stays at one cycle
    run_vec(8'd1, 9'h1FF, 60);
    begin
      int off = 0;
      for (int i = 0; i < 60; i++) if (ival(i) != 1) off++;
      chk("R8", "shortened unit period not one cycle", off, 0);
    end

    // R4 with R5/R6: long-run correction density
    long_run(9'h064, 11, "R5");
    long_run(9'h164, 9, "R6");

    // R1: reset in mid-run, then a fresh run must match the table vector 0
    div = 8'd10;
    rate = 9'h0FF;
    en = 1'b1;
    repeat (23) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "tick while reset mid-run", int'(tick), 0);
    en = 1'b0;
    rst_n = 1'b1;
    run_vec(8'd10, 9'h0FF, 5);
    for (int i = 0; i < 5; i++)
      chk("R1", $sformatf("restart interval %0d", i), ival(i), int'(VECS[0].ex[i]));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule